// File: doc/BRIEF.md
# CPU Bus Supervisor and Interrupt Glue

This block is the support logic that sits beside a 16-bit processor with an asynchronous bus: address strobe, upper and lower data strobes, a three-bit function code and a transfer acknowledge. It watches every bus cycle for a missing acknowledge and ends a stalled cycle with a bus error. It turns seven active-low interrupt request lines into the processor's three-bit active-low priority code and answers interrupt acknowledge cycles with an autovector request. It also turns the power supply's master reset into the processor reset and halt drive, and it gates the select of the battery-backed RAM.

Three state machines do the work. The bus watchdog has the states WD_IDLE, WD_COUNT and WD_FAULT. WD_IDLE goes to WD_COUNT on a sampled low strobe. WD_COUNT goes back to WD_IDLE on a high strobe, or goes to WD_FAULT when the count limit is reached with the strobe still low. WD_FAULT goes to WD_IDLE on a high strobe. The reset gate has the states RG_HOLD, RG_STRETCH and RG_RUN. A low master reset forces RG_HOLD at once. RG_HOLD goes to RG_STRETCH on the first edge with master reset high. RG_STRETCH goes to RG_RUN after the stretch count. The interrupt path is a two-flop synchroniser per line followed by a priority encoder.

Only the upper address bits, A23 to A16, come into the block, because it decodes nothing but the RAM window. No device in the block ever returns an acknowledge for a data access. An access to an unmapped hole, such as the region just below the stack, therefore runs into the watchdog and ends in a bus error.

Top module: `cpu_bus_supervisor`

## Requirements
- R1: `berr_n` goes low on the clock edge that samples `as_n` low for the 193rd consecutive time (limit 192), and never earlier within a strobe.
- R2: Once low, `berr_n` stays low while `as_n` stays low. It returns high after the first edge that samples `as_n` high, and the count then restarts from zero for the next strobe.
- R3: `vpa_n` is low, with no clock delay, exactly when `as_n` is low and `fc` equals 3'b111 (interrupt acknowledge). It is high for every other function code.
- R4: `ipl_n` is the bitwise inverse of the highest level L (1 to 7) whose request line `irq_n[L-1]` is low, after synchronisation. It is 3'b111 when no line is low.
- R5: A change on `irq_n` reaches `ipl_n` on the second rising edge after it is applied, and not on the first.
- R6: Level 7 (`irq_n[6]`, the non-maskable level) gives `ipl_n` = 3'b000 whatever the lower lines do.
- R7: While `mst_rst_n` is low, `cpu_rst_n` and `cpu_halt_n` are both low.
- R8: After `mst_rst_n` rises, `cpu_rst_n` and `cpu_halt_n` stay low through the first 10 rising edges and go high together on the 11th.
- R9: `nvram_sel_n` is low exactly when `mst_rst_n` is high, `as_n` is low, at least one of `uds_n` and `lds_n` is low, `fc` is not 3'b111, and `adr_hi` equals the RAM tag 8'h01.
- R10: While `mst_rst_n` is low, `nvram_sel_n` is high whatever the bus is doing.
- R11: A data access to an address outside the RAM tag gets no response from the block: `vpa_n` and `nvram_sel_n` stay high until the watchdog raises the bus error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| mst_rst_n | input | 1 | Power-fail master reset, active low; also resets this block |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| fc | input | 3 | Processor function code |
| adr_hi | input | 8 | Upper address bits A23..A16 |
| irq_n | input | 7 | Interrupt requests, bit i is level i+1, active low |
| berr_n | output | 1 | Bus error to the processor, active low |
| vpa_n | output | 1 | Autovector request, active low |
| ipl_n | output | 3 | Interrupt priority code, active low |
| cpu_rst_n | output | 1 | Processor reset drive, active low |
| cpu_halt_n | output | 1 | Processor halt drive, active low |
| nvram_sel_n | output | 1 | Battery-backed RAM select, active low |

## Verification
The bench probes the watchdog on both sides of the limit. An off-by-one counter would flag the 192nd edge or miss the 193rd. A counter that was not cleared between strobes would fault early on a second long cycle that follows a short release. A non-sticky error would let the cycle go on. The interrupt path is sampled after one edge and after two edges, and with overlapping levels. A missing synchroniser stage, or an encoder that favours the lowest level, would show the wrong code. The reset stretch is checked on the 10th and 11th edges, and the RAM select is driven with a live RAM access during master reset, where leaky gating would select the RAM.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_COUNT,
        WD_FAULT
    } wd_state_t;

    typedef enum logic [1:0] {
        RG_HOLD,
        RG_STRETCH,
        RG_RUN
    } rg_state_t;

    localparam logic [2:0] FC_IACK = 3'b111;

endpackage

// File: rtl/cbs_bus_watchdog.sv
module cbs_bus_watchdog
    import cbs_pkg::*;
#(
    parameter int LIMIT = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    output logic berr_n
);
    localparam int CW = $clog2(LIMIT + 1);

    wd_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            WD_IDLE: begin
                if (!as_n) begin
                    st_d  = WD_COUNT;
                    cnt_d = CW'(1);
                end
            end
            WD_COUNT: begin
                if (as_n) begin
                    st_d  = WD_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == CW'(LIMIT)) begin
                    st_d  = WD_FAULT;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            WD_FAULT: begin
                if (as_n) st_d = WD_IDLE;
            end
            default: st_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        berr_n = (st_q != WD_FAULT);
    end

endmodule

// File: rtl/cbs_irq_encoder.sv
module cbs_irq_encoder #(
    parameter int LEVELS = 7,
    parameter int IPL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] irq_n,
    output logic [IPL_W-1:0]  ipl_n
);
    logic [LEVELS-1:0] req_n_sync;

    for (genvar g = 0; g < LEVELS; g++) begin : g_sync
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= irq_n[g];
                stab_q <= meta_q;
            end
        end
        assign req_n_sync[g] = stab_q;
    end

    logic [IPL_W-1:0] level;

    always_comb begin
        level = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (!req_n_sync[i]) level = IPL_W'(i + 1);
        end
        ipl_n = ~level;
    end

endmodule

// File: rtl/cbs_reset_gate.sv
module cbs_reset_gate
    import cbs_pkg::*;
#(
    parameter int STRETCH = 10
) (
    input  logic clk,
    input  logic mst_rst_n,
    output logic cpu_rst_n,
    output logic cpu_halt_n
);
    localparam int CW = $clog2(STRETCH + 1);

    rg_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge mst_rst_n) begin
        if (!mst_rst_n) begin
            st_q  <= RG_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RG_HOLD: begin
                st_d  = RG_STRETCH;
                cnt_d = '0;
            end
            RG_STRETCH: begin
                if (cnt_q == CW'(STRETCH - 1)) st_d = RG_RUN;
                else                           cnt_d = cnt_q + CW'(1);
            end
            RG_RUN:  st_d = RG_RUN;
            default: st_d = RG_HOLD;
        endcase
    end

    // both lines released together, forced low at once by master reset
    always_comb begin
        cpu_rst_n  = (st_q == RG_RUN) && mst_rst_n;
        cpu_halt_n = (st_q == RG_RUN) && mst_rst_n;
    end

endmodule

// File: rtl/cpu_bus_supervisor.sv
module cpu_bus_supervisor
    import cbs_pkg::*;
#(
    parameter int         WD_LIMIT    = 192,
    parameter int         RST_STRETCH = 10,
    parameter int         IRQ_LEVELS  = 7,
    parameter int         TAG_W       = 8,
    parameter logic [7:0] RAM_TAG     = 8'h01
) (
    input  logic                                clk,
    input  logic                                mst_rst_n,
    input  logic                                as_n,
    input  logic                                uds_n,
    input  logic                                lds_n,
    input  logic [2:0]                          fc,
    input  logic [TAG_W-1:0]                    adr_hi,
    input  logic [IRQ_LEVELS-1:0]               irq_n,
    output logic                                berr_n,
    output logic                                vpa_n,
    output logic [$clog2(IRQ_LEVELS+1)-1:0]     ipl_n,
    output logic                                cpu_rst_n,
    output logic                                cpu_halt_n,
    output logic                                nvram_sel_n
);
    localparam int IPL_W = $clog2(IRQ_LEVELS + 1);

    cbs_bus_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
        .clk    (clk),
        .rst_n  (mst_rst_n),
        .as_n   (as_n),
        .berr_n (berr_n)
    );

    cbs_irq_encoder #(.LEVELS(IRQ_LEVELS), .IPL_W(IPL_W)) u_irq (
        .clk   (clk),
        .rst_n (mst_rst_n),
        .irq_n (irq_n),
        .ipl_n (ipl_n)
    );

    cbs_reset_gate #(.STRETCH(RST_STRETCH)) u_rg (
        .clk        (clk),
        .mst_rst_n  (mst_rst_n),
        .cpu_rst_n  (cpu_rst_n),
        .cpu_halt_n (cpu_halt_n)
    );

    logic iack, ram_hit, strobe;

    always_comb begin
        iack        = !as_n && (fc == FC_IACK);
        strobe      = !uds_n || !lds_n;
        ram_hit     = (adr_hi == RAM_TAG[TAG_W-1:0]);
        vpa_n       = !iack;
        nvram_sel_n = !(mst_rst_n && !as_n && strobe && !iack && ram_hit);
    end

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int LIMIT   = 192,
    parameter int STRETCH = 10,
    parameter int LEVELS  = 7,
    parameter int IPL_W   = 3
) (
    input logic              clk,
    input logic              mst_rst_n,
    input logic              as_n,
    input logic [LEVELS-1:0] irq_n,
    input logic              berr_n,
    input logic              vpa_n,
    input logic [IPL_W-1:0]  ipl_n,
    input logic              cpu_rst_n,
    input logic              cpu_halt_n,
    input logic              nvram_sel_n
);
    int low_run;
    int since_rel;

    always_ff @(posedge clk or negedge mst_rst_n) begin
        if (!mst_rst_n) begin
            low_run   <= 0;
            since_rel <= 0;
        end else begin
            if (as_n)                 low_run <= 0;
            else if (low_run < LIMIT + 4) low_run <= low_run + 1;
            if (since_rel < STRETCH + 4) since_rel <= since_rel + 1;
        end
    end

    assert_berr_not_early_R1: assert property (@(posedge clk) disable iff (!mst_rst_n)
        !berr_n |-> (low_run > LIMIT));
    assert_berr_on_time_R1: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (low_run == LIMIT + 1) |-> !berr_n);
    assert_berr_sticky_R2: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (!berr_n && !as_n) |=> !berr_n);
    assert_berr_release_R2: assert property (@(posedge clk) disable iff (!mst_rst_n)
        as_n |=> berr_n);
    assert_iack_no_ram_R3: assert property (@(posedge clk) disable iff (!mst_rst_n)
        !vpa_n |-> nvram_sel_n);
    assert_nmi_top_R6: assert property (@(posedge clk) disable iff (!mst_rst_n)
        ((since_rel >= 3) && !irq_n[LEVELS-1] && !$past(irq_n[LEVELS-1])
            && !$past(irq_n[LEVELS-1], 2)) |-> (ipl_n == '0));
    assert_mst_forces_R7: assert property (@(posedge clk)
        !mst_rst_n |-> (!cpu_rst_n && !cpu_halt_n));
    assert_stretch_min_R8: assert property (@(posedge clk) disable iff (!mst_rst_n)
        cpu_rst_n |-> (since_rel > STRETCH));
    assert_stretch_end_R8: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (since_rel > STRETCH) |-> (cpu_rst_n && cpu_halt_n));
    assert_ram_locked_R10: assert property (@(posedge clk)
        !mst_rst_n |-> nvram_sel_n);

endmodule

bind cpu_bus_supervisor cbs_checker #(
    .LIMIT   (WD_LIMIT),
    .STRETCH (RST_STRETCH),
    .LEVELS  (IRQ_LEVELS),
    .IPL_W   (IPL_W)
) u_cbs_checker (
    .clk         (clk),
    .mst_rst_n   (mst_rst_n),
    .as_n        (as_n),
    .irq_n       (irq_n),
    .berr_n      (berr_n),
    .vpa_n       (vpa_n),
    .ipl_n       (ipl_n),
    .cpu_rst_n   (cpu_rst_n),
    .cpu_halt_n  (cpu_halt_n),
    .nvram_sel_n (nvram_sel_n)
);

// File: tb/test_cpu_bus_supervisor.sv
module test_cpu_bus_supervisor;

    logic       clk = 1'b0;
    logic       mst_rst_n;
    logic       as_n, uds_n, lds_n;
    logic [2:0] fc;
    logic [7:0] adr_hi;
    logic [6:0] irq_n;
    logic       berr_n, vpa_n, cpu_rst_n, cpu_halt_n, nvram_sel_n;
    logic [2:0] ipl_n;

    always #10 clk = ~clk;

    cpu_bus_supervisor i_cpu_bus_supervisor (
        .clk         (clk),
        .mst_rst_n   (mst_rst_n),
        .as_n        (as_n),
        .uds_n       (uds_n),
        .lds_n       (lds_n),
        .fc          (fc),
        .adr_hi      (adr_hi),
        .irq_n       (irq_n),
        .berr_n      (berr_n),
        .vpa_n       (vpa_n),
        .ipl_n       (ipl_n),
        .cpu_rst_n   (cpu_rst_n),
        .cpu_halt_n  (cpu_halt_n),
        .nvram_sel_n (nvram_sel_n)
    );

    typedef enum int {O_BERR, O_VPA, O_IPL, O_RST, O_HALT, O_SEL} out_t;
    typedef struct {
        string      req;
        out_t       which;
        logic [2:0] exp;
    } item_t;

    item_t q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic expect_out(input string req, input out_t which, input logic [2:0] exp);
        item_t it;
        it.req = req; it.which = which; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] observe(input out_t which);
        case (which)
            O_BERR:  return {2'b0, berr_n};
            O_VPA:   return {2'b0, vpa_n};
            O_IPL:   return ipl_n;
            O_RST:   return {2'b0, cpu_rst_n};
            O_HALT:  return {2'b0, cpu_halt_n};
            default: return {2'b0, nvram_sel_n};
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [2:0] act;
                it  = q.pop_front();
                act = observe(it.which);
                n_vec++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.which.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        mst_rst_n = 1'b1;
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        fc = 3'b000; adr_hi = 8'h00; irq_n = 7'h7f;
        #1 mst_rst_n = 1'b0;
        step(2);
        // reset state
        expect_out("R7", O_RST, 3'd0);
        expect_out("R7", O_HALT, 3'd0);
        expect_out("R4", O_IPL, 3'b111);
        // live RAM access during master reset
        as_n = 1'b0; uds_n = 1'b0; fc = 3'b101; adr_hi = 8'h01;
        expect_out("R10", O_SEL, 3'd1);
        step(1);
        as_n = 1'b1; uds_n = 1'b1;
        step(1);

        // release and stretch
        mst_rst_n = 1'b1;
        step(10);
        expect_out("R8", O_RST, 3'd0);
        expect_out("R8", O_HALT, 3'd0);
        step(1);
        expect_out("R8", O_RST, 3'd1);
        expect_out("R8", O_HALT, 3'd1);
        step(1);

        // RAM select and autovector
        as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b1; fc = 3'b101; adr_hi = 8'h01;
        expect_out("R9", O_SEL, 3'd0);
        expect_out("R3", O_VPA, 3'd1);
        step(1);
        fc = 3'b111;
        expect_out("R3", O_VPA, 3'd0);
        expect_out("R9", O_SEL, 3'd1);
        step(1);
        fc = 3'b110;
        expect_out("R3", O_VPA, 3'd1);
        expect_out("R9", O_SEL, 3'd0);
        step(1);
        adr_hi = 8'h02;
        expect_out("R9", O_SEL, 3'd1);
        step(1);
        adr_hi = 8'h01; uds_n = 1'b1;
        expect_out("R9", O_SEL, 3'd1);
        step(1);
        as_n = 1'b1;
        step(2);

        // unmapped access runs into the watchdog
        as_n = 1'b0; lds_n = 1'b0; fc = 3'b101; adr_hi = 8'h00;
        step(192);
        expect_out("R1", O_BERR, 3'd1);
        expect_out("R11", O_VPA, 3'd1);
        expect_out("R11", O_SEL, 3'd1);
        step(1);
        expect_out("R1", O_BERR, 3'd0);
        step(5);
        expect_out("R2", O_BERR, 3'd0);
        as_n = 1'b1; lds_n = 1'b1;
        expect_out("R2", O_BERR, 3'd0);
        step(1);
        expect_out("R2", O_BERR, 3'd1);
        // count restarts after a short release
        as_n = 1'b0;
        step(100);
        as_n = 1'b1;
        step(1);
        as_n = 1'b0;
        step(192);
        expect_out("R2", O_BERR, 3'd1);
        step(1);
        expect_out("R1", O_BERR, 3'd0);
        as_n = 1'b1;
        step(1);
        expect_out("R2", O_BERR, 3'd1);

        // interrupt priority
        irq_n = 7'b1111011;          // level 3
        step(1);
        expect_out("R5", O_IPL, 3'b111);
        step(1);
        expect_out("R4", O_IPL, 3'b100);
        irq_n = 7'b1101101;          // levels 2 and 5
        step(2);
        expect_out("R4", O_IPL, 3'b010);
        irq_n = 7'b1111110;          // level 1
        step(2);
        expect_out("R4", O_IPL, 3'b110);
        irq_n = 7'b0000000;          // all, including level 7
        step(2);
        expect_out("R6", O_IPL, 3'b000);
        irq_n = 7'b0011111;          // levels 6 and 7
        step(2);
        expect_out("R6", O_IPL, 3'b000);
        irq_n = 7'b1010111;          // levels 4 and 6
        step(2);
        expect_out("R4", O_IPL, 3'b001);
        irq_n = 7'h7f;
        step(2);
        expect_out("R4", O_IPL, 3'b111);

        // master reset during a RAM access
        as_n = 1'b0; uds_n = 1'b0; fc = 3'b101; adr_hi = 8'h01;
        expect_out("R9", O_SEL, 3'd0);
        step(1);
        mst_rst_n = 1'b0;
        expect_out("R10", O_SEL, 3'd1);
        expect_out("R7", O_RST, 3'd0);
        expect_out("R7", O_HALT, 3'd0);
        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule